// File: doc/BRIEF.md
# Sweep-Reference Comparator Quantizer

This block turns a signed column accumulation value into a quantized code by stepping a digital reference upward one level per clock. Each step yields one decision bit: the held value either reaches the current reference level or it does not. The decision bits form a thermometer vector, and a running count of its ones gives the binary code.

A conversion begins with a one-cycle start strobe, which also samples the signed input. Busy is high while the sweep runs. A one-cycle done pulse marks the point at which the thermometer vector and the count are valid. Both results then stay unchanged until the next accepted start. Each instance serves one column.

With the default output resolution of 6 bits, the sweep has 2^(6-1)+1 = 33 levels. They run from -32 to +32 in steps of 2.

Top module: `sweep_quantizer`

## Requirements
- R1: When start is high while busy is low, the input value is captured at that clock edge. Busy is high from the next cycle and stays high for exactly 33 cycles.
- R2: Compare step k (k = 0..32) uses reference -32 + 2k, and its decision is stored in thermometer bit k. Bit 0 therefore belongs to reference -32, and bit 32 to reference +32.
- R3: A decision bit is 1 when the captured value is greater than or equal to its reference. An exactly equal value gives 1. A value one below the reference gives 0.
- R4: At done, the thermometer vector is of the form 0...01...1, with all set bits at the low end.
- R5: The count output is an unsigned 6-bit number equal to the number of ones in the thermometer vector, from 0 to 33.
- R6: Done is high for exactly one cycle: the first cycle in which busy is low again. The thermometer vector and the count are valid in that cycle and hold their values until the next accepted start.
- R7: A start strobe received while busy is high, including in the last busy cycle, is ignored. It does not lengthen the sweep and does not alter the results.
- R8: Changes on the value input after capture have no effect on the conversion.
- R9: A value below -32 gives all zeros and count 0. A value of +32 or above gives all ones and count 33.
- R10: After reset, busy and done are low, and the thermometer vector and the count are zero.
- R11: A start strobe in the cycle where done is high is accepted. Busy is high in the following cycle, and the new conversion runs normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe; also samples value |
| value | input | 10 | Signed two's complement accumulation value |
| busy | output | 1 | High during the compare sweep |
| done | output | 1 | One-cycle pulse when results are valid |
| thermo | output | 33 | Thermometer code, bit k for reference -32+2k |
| count | output | 6 | Number of ones in thermo |

## Verification
Two functions can fall in the same cycle: accepting a new start, and presenting the finished result of the previous sweep. To provoke this, the bench raises start exactly in the done cycle. It then checks that the old results were intact in that cycle, that busy rises on the next one, and that the new sweep yields its own expected code. The opposite case is also provoked: a start in the final busy cycle, where the sweep is still running. The bench checks that this start is dropped and that busy stays low after done.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;   // capture input and clear results
    logic cmp;    // perform one compare step this cycle
  } sweepStrobes_t;

  // Number of reference levels for an N-bit result: 2^(N-1)+1.
  function automatic int levelsFor(input int outBits);
    return (1 << (outBits - 1)) + 1;
  endfunction

  // Lowest reference level: -(2^(N-1)).
  function automatic int refStartFor(input int outBits);
    return -(1 << (outBits - 1));
  endfunction

endpackage

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int LEVELS = 33,
  parameter int IDX_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] stepIdx,
  output sweepStrobes_t    strobes
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEVELS - 1);

  logic accept;
  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepIdx <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        stepIdx <= '0;
      end else if (busy) begin
        if (stepIdx == LAST_IDX) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          stepIdx <= stepIdx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.load = accept;
    strobes.cmp  = busy;
  end

endmodule

// File: rtl/sweep_datapath.sv
module sweep_datapath
  import sweep_pkg::*;
#(
  parameter int VALUE_W   = 10,
  parameter int LEVELS    = 33,
  parameter int REF_START = -32,
  parameter int REF_STEP  = 2,
  parameter int IDX_W     = 6,
  parameter int COUNT_W   = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sweepStrobes_t             strobes,
  input  logic [IDX_W-1:0]          stepIdx,
  input  logic signed [VALUE_W-1:0] valueIn,
  output logic [LEVELS-1:0]         thermo,
  output logic [COUNT_W-1:0]        count
);

  logic signed [VALUE_W-1:0] heldValue;
  int                        refLevel;
  logic                      decision;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             heldValue <= '0;
    else if (strobes.load) heldValue <= valueIn;
  end

  // Reference for the current step, and the >= decision.
  always_comb begin
    refLevel = REF_START + REF_STEP * int'(stepIdx);
    decision = int'(heldValue) >= refLevel;
  end

  // One register per reference level.
  for (genvar g = 0; g < LEVELS; g++) begin : g_level
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        thermo[g] <= 1'b0;
      else if (strobes.load)
        thermo[g] <= 1'b0;
      else if (strobes.cmp && stepIdx == IDX_W'(g))
        thermo[g] <= decision;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             count <= '0;
    else if (strobes.load) count <= '0;
    else if (strobes.cmp)  count <= count + COUNT_W'(decision);
  end

endmodule

// File: rtl/sweep_quantizer.sv
module sweep_quantizer
  import sweep_pkg::*;
#(
  parameter int VALUE_W  = 10,
  parameter int OUT_BITS = 6,
  parameter int REF_STEP = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic signed [VALUE_W-1:0] value,
  output logic                      busy,
  output logic                      done,
  output logic [levelsFor(OUT_BITS)-1:0]          thermo,
  output logic [$clog2(levelsFor(OUT_BITS)+1)-1:0] count
);

  localparam int LEVELS    = levelsFor(OUT_BITS);
  localparam int REF_START = refStartFor(OUT_BITS);
  localparam int IDX_W     = $clog2(LEVELS);
  localparam int COUNT_W   = $clog2(LEVELS + 1);

  sweepStrobes_t    strobes;
  logic [IDX_W-1:0] stepIdx;

  sweep_ctrl #(
    .LEVELS (LEVELS),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .stepIdx (stepIdx),
    .strobes (strobes)
  );

  sweep_datapath #(
    .VALUE_W   (VALUE_W),
    .LEVELS    (LEVELS),
    .REF_START (REF_START),
    .REF_STEP  (REF_STEP),
    .IDX_W     (IDX_W),
    .COUNT_W   (COUNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .stepIdx (stepIdx),
    .valueIn (value),
    .thermo  (thermo),
    .count   (count)
  );

endmodule

// File: rtl/sweep_quantizer_chk.sv
module sweep_quantizer_chk
  import sweep_pkg::*;
#(
  parameter int VALUE_W  = 10,
  parameter int OUT_BITS = 6,
  parameter int REF_STEP = 2
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      start,
  input logic signed [VALUE_W-1:0] value,
  input logic                      busy,
  input logic                      done,
  input logic [levelsFor(OUT_BITS)-1:0]          thermo,
  input logic [$clog2(levelsFor(OUT_BITS)+1)-1:0] count
);

  localparam int LEVELS  = levelsFor(OUT_BITS);
  localparam int COUNT_W = $clog2(LEVELS + 1);
  localparam int SPAN_W  = $clog2(LEVELS + 2);

  // Length of the current busy run, measured by counter.
  logic [SPAN_W-1:0] busySpan;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busySpan <= '0;
    else if (busy) busySpan <= busySpan + 1'b1;
    else           busySpan <= '0;
  end

  // R1: a sweep lasts exactly LEVELS cycles
  a_r1_busy_span: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busySpan == SPAN_W'(LEVELS));

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: done appears exactly when busy has just dropped
  a_r6_done_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R5: count equals ones in the thermometer vector
  a_r5_count_ones: assert property (@(posedge clk) disable iff (!rstN)
    done |-> count == COUNT_W'($countones(thermo)));

  // R4: thermometer shape, ones packed at the low end
  a_r4_thermo_shape: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((thermo & (thermo + LEVELS'(1))) == '0));

  // R7: a start during busy does not restart or extend the run
  a_r7_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && busySpan < SPAN_W'(LEVELS - 1)) |=> busy);

endmodule

bind sweep_quantizer sweep_quantizer_chk #(
  .VALUE_W  (VALUE_W),
  .OUT_BITS (OUT_BITS),
  .REF_STEP (REF_STEP)
) u_chk (.*);

// File: tb/tb_sweep_quantizer.sv
module tb_sweep_quantizer;

  localparam int VALUE_W = 10;
  localparam int LEVELS  = 33;
  localparam int COUNT_W = 6;
  localparam int NVEC    = 12;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic                      start = 1'b0;
  logic signed [VALUE_W-1:0] value = '0;
  logic                      busy;
  logic                      done;
  logic [LEVELS-1:0]         thermo;
  logic [COUNT_W-1:0]        count;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sweep_quantizer dut (
    .clk(clk), .rstN(rstN), .start(start), .value(value),
    .busy(busy), .done(done), .thermo(thermo), .count(count)
  );

  // Stimulus value and expected count of ones.
  localparam int VEC_VAL [NVEC] = '{-256, -33, -32, -31, -30, -1, 0, 1, 30, 31, 32, 256};
  localparam int VEC_CNT [NVEC] = '{   0,   0,   1,   1,   2, 16, 17, 17, 32, 32, 33,  33};

  function automatic logic [LEVELS-1:0] expThermo(input int c);
    logic [LEVELS-1:0] t = '0;
    for (int k = 0; k < LEVELS; k++) if (k < c) t[k] = 1'b1;
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart(input int v);
    @(negedge clk);
    start = 1'b1;
    value = VALUE_W'(v);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Called just after start was released at a negedge.
  // injectAt: busy cycle at which a stray start is driven (-1 none).
  // chain: launch a new conversion in the done cycle.
  task automatic waitCheck(input int expCnt, input int injectAt,
                           input bit chain, input int chainV);
    int span;
    int guard;
    span  = busy ? 1 : 0;
    guard = 0;
    check(busy == 1'b1, "R1", "busy after start", longint'(busy), 1);
    while (!done && guard < 64) begin
      value = VALUE_W'(span * 37 - 200);  // R8: scramble input
      start = (span == injectAt);         // R7: stray start
      @(negedge clk);
      start = 1'b0;
      if (busy) span++;
      guard++;
    end
    check(done == 1'b1, "R6", "done seen", longint'(done), 1);
    check(span == LEVELS, "R1", "busy span", span, LEVELS);
    check(busy == 1'b0, "R6", "busy low at done", longint'(busy), 0);
    check(count == COUNT_W'(expCnt), "R5", "count", longint'(count), expCnt);
    check(thermo == expThermo(expCnt), "R2 R3 R4", "thermo",
          longint'(thermo), longint'(expThermo(expCnt)));
    if (chain) begin
      start = 1'b1;                       // R11: start in the done cycle
      value = VALUE_W'(chainV);
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R11", "busy after done-cycle start", longint'(busy), 1);
      check(done == 1'b0, "R6", "done single", longint'(done), 0);
    end else begin
      @(negedge clk);
      check(done == 1'b0, "R6", "done single", longint'(done), 0);
      check(busy == 1'b0, "R7", "no restart", longint'(busy), 0);
      check(count == COUNT_W'(expCnt), "R6", "count holds", longint'(count), expCnt);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0, "R10", "busy in reset", longint'(busy), 0);
    check(done == 1'b0, "R10", "done in reset", longint'(done), 0);
    check(thermo == '0, "R10", "thermo in reset", longint'(thermo), 0);
    check(count == '0, "R10", "count in reset", longint'(count), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R10", "idle after reset", longint'(busy), 0);

    // Table walk: R2 R3 R9 and equality boundaries
    for (int i = 0; i < NVEC; i++) begin
      pulseStart(VEC_VAL[i]);
      waitCheck(VEC_CNT[i], -1, 1'b0, 0);
    end

    // R7: stray start mid-sweep with a different value
    pulseStart(5);                 // expect 19
    waitCheck(19, 10, 1'b0, 0);

    // R7: stray start in the final busy cycle
    pulseStart(-20);               // expect 7
    waitCheck(7, LEVELS, 1'b0, 0);

    // R11: start in done cycle, then second result
    pulseStart(-2);                // expect 16
    waitCheck(16, -1, 1'b1, 3);    // chained value 3 -> 18
    waitCheck(18, -1, 1'b0, 0);

    // R9: extreme negative after a full result clears to zero
    pulseStart(-512);
    waitCheck(0, -1, 1'b0, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule